// File: doc/BRIEF.md
# BCD Seven-Segment Latching Decoder

This block turns a 4-bit binary-coded decimal value into the seven active-high segment lines of a single digit, labelled a through g. There is no decimal-point line. The decoded pattern passes through a hold register that can freeze the displayed digit. Two overrides sit in front of the output: one lights every segment, and the other forces every segment off.

All inputs are sampled on the rising edge of `clk_i`. The segment outputs are registered, so they show the inputs captured at the previous rising edge. The three controls are active low. They resolve in a fixed order: lamp test first, then blanking, then the latch. The six codes above nine produce a dark digit and never a hex glyph. The hold register stores the decoded segment pattern and not the raw code.

Top module: `seg_latch_decoder`

## Requirements
- R1: `code_i` is weighted D=bit 3 (MSB) down to A=bit 0 (LSB). `seg_o` carries exactly seven segments, with a=bit 0, b=bit 1, c=bit 2, d=bit 3, e=bit 4, f=bit 5 and g=bit 6. `seg_o` shows the inputs sampled at the previous rising edge of `clk_i`.
- R2: While `test_ni` is 0, `seg_o` is 7'h7F, whatever `blank_ni`, `latch_ni` and `code_i` are.
- R3: While `test_ni` is 1 and `blank_ni` is 0, `seg_o` is 7'h00, whatever `latch_ni` and `code_i` are.
- R4: While `test_ni`, `blank_ni` and `latch_ni` are all 1, `seg_o` keeps the pattern that was last stored and ignores `code_i`.
- R5: While `test_ni` and `blank_ni` are 1 and `latch_ni` is 0, `seg_o` follows the decoded code. The patterns are 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D (with top bar), 7=7'h07, 8=7'h7F and 9=7'h6F (with bottom bar).
- R6: Codes 10 to 15 decode to 7'h00.
- R7: The hold register loads the decoded pattern on every edge where `latch_ni` is 0, whatever the overrides are. It keeps that pattern otherwise. Lamp test or blanking applied while the register is holding leaves the stored pattern unchanged.
- R8: Asserting `rst_ni` low clears `seg_o` and the hold register to the blank pattern 7'h00. After release with `latch_ni` at 1, `seg_o` stays 7'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 4 | BCD code, D..A |
| latch_ni | input | 1 | Latch enable, active low (low = follow, high = hold) |
| blank_ni | input | 1 | Blanking, active low |
| test_ni | input | 1 | Lamp test, active low |
| seg_o | output | 7 | Segments a..g, active high |

## Verification
The hardest state to confirm from the ports is the stored pattern while an override hides it. The bench loads a digit, then raises the latch and changes the code to other digits. It applies lamp test and blanking in turn while the code keeps changing. When it drops both overrides, the original digit must reappear. A reference model runs through every code against all eight control combinations in sequence. This reaches every transition into and out of hold, both from a visible state and from an overridden one.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned SEG_N  = 7;
  typedef logic [SEG_N-1:0] seg_t;
  localparam seg_t SEG_DARK = '0;
  localparam seg_t SEG_FULL = '1;
endpackage

// File: rtl/seg_decode.sv
module seg_decode
  import seg_pkg::*;
#(
  parameter int unsigned CW = CODE_W
) (
  input  logic [CW-1:0] code_i,
  output seg_t          seg_o
);
  always_comb begin
    unique case (code_i)
      CW'(0):  seg_o = 7'h3F;
      CW'(1):  seg_o = 7'h06;
      CW'(2):  seg_o = 7'h5B;
      CW'(3):  seg_o = 7'h4F;
      CW'(4):  seg_o = 7'h66;
      CW'(5):  seg_o = 7'h6D;
      CW'(6):  seg_o = 7'h7D;
      CW'(7):  seg_o = 7'h07;
      CW'(8):  seg_o = 7'h7F;
      CW'(9):  seg_o = 7'h6F;
      default: seg_o = SEG_DARK; // non-decimal codes stay dark
    endcase
  end
endmodule

// File: rtl/seg_hold.sv
module seg_hold
  import seg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  seg_t pat_i,
  output seg_t held_o
);
  seg_t held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= SEG_DARK;
    else if (load_i) held_q <= pat_i;
  end

  assign held_o = held_q;

  // R7
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(held_q));
endmodule

// File: rtl/seg_override.sv
module seg_override
  import seg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_ni,
  input  logic blank_ni,
  input  seg_t pat_i,
  output seg_t seg_o
);
  seg_t seg_d, seg_q;

  // lamp test outranks blanking
  always_comb begin
    if (!test_ni)       seg_d = SEG_FULL;
    else if (!blank_ni) seg_d = SEG_DARK;
    else                seg_d = pat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seg_q <= SEG_DARK;
    else         seg_q <= seg_d;
  end

  assign seg_o = seg_q;

  // R2
  lamp_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_ni |=> seg_q == SEG_FULL);
  // R3
  blank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_ni && !blank_ni |=> seg_q == SEG_DARK);
endmodule

// File: rtl/seg_latch_decoder.sv
module seg_latch_decoder
  import seg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              latch_ni,
  input  logic              blank_ni,
  input  logic              test_ni,
  output logic [SEG_N-1:0]  seg_o
);
  seg_t dec_pat, held_pat, sel_pat;

  seg_decode #(.CW(CODE_W)) u_dec (
    .code_i (code_i),
    .seg_o  (dec_pat)
  );

  seg_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (!latch_ni),
    .pat_i  (dec_pat),
    .held_o (held_pat)
  );

  // transparent path bypasses the register
  assign sel_pat = latch_ni ? held_pat : dec_pat;

  seg_override u_ovr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .test_ni  (test_ni),
    .blank_ni (blank_ni),
    .pat_i    (sel_pat),
    .seg_o    (seg_o)
  );

  // R4
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_ni && blank_ni && latch_ni && $past(test_ni && blank_ni && rst_ni)
      |=> $stable(seg_o));
  // R6
  non_bcd_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_ni && blank_ni && !latch_ni && code_i > 4'd9 |=> seg_o == 7'h00);
  // R5
  eight_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_ni && blank_ni && !latch_ni && code_i == 4'd8 |=> seg_o == 7'h7F);
endmodule

// File: tb/tb_seg_latch_decoder.sv
module tb_seg_latch_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] code_i = '0;
  logic       latch_ni = 1'b1, blank_ni = 1'b1, test_ni = 1'b1;
  logic [6:0] seg_o;
  logic [6:0] held_ref = 7'h00;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i; // 50 MHz

  seg_latch_decoder dut (.*);

  function automatic logic [6:0] ref_pat(input logic [3:0] c);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (c < 4'd10) ? t[c] : 7'h00;
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    checks++;
    if (seg_o !== exp) begin
      errors++;
      $display("FAIL %s: seg_o=%h expected=%h", req, seg_o, exp);
    end
  endtask

  // drive at negedge, registered result visible at the following negedge
  task automatic apply(input logic [3:0] c, input logic le, bl, lt,
                       output logic [6:0] exp);
    @(negedge clk_i);
    code_i = c; latch_ni = le; blank_ni = bl; test_ni = lt;
    if (!lt)      exp = 7'h7F;
    else if (!bl) exp = 7'h00;
    else if (le)  exp = held_ref;
    else          exp = ref_pat(c);
    if (!le) held_ref = ref_pat(c);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [6:0] e;
    apply(4'd5, 1'b0, 1'b1, 1'b1, e);
    @(negedge clk_i); rst_ni = 1'b0; latch_ni = 1'b1; held_ref = 7'h00;
    #1 check("R8 async clear", 7'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    apply(4'd3, 1'b1, 1'b1, 1'b1, e);
    check("R8 hold blank after reset", e);
  endtask

  task automatic t_decode_all();
    logic [6:0] e;
    for (int i = 0; i < 16; i++) begin
      apply(4'(i), 1'b0, 1'b1, 1'b1, e);
      check(i < 10 ? "R5 decode" : "R6 non-decimal dark", e);
    end
    apply(4'b1000, 1'b0, 1'b1, 1'b1, e); check("R1 D weight", 7'h7F);
    apply(4'b0001, 1'b0, 1'b1, 1'b1, e); check("R1 A weight", 7'h06);
  endtask

  task automatic t_overrides();
    logic [6:0] e;
    for (int i = 0; i < 16; i++) begin
      apply(4'(i), i[0], i[1], 1'b0, e); check("R2 lamp test", 7'h7F);
      apply(4'(i), i[0], 1'b0, 1'b1, e); check("R3 blanking", 7'h00);
    end
  endtask

  task automatic t_hold();
    logic [6:0] e;
    apply(4'd3, 1'b0, 1'b1, 1'b1, e); check("R5 load 3", 7'h4F);
    apply(4'd6, 1'b1, 1'b1, 1'b1, e); check("R4 hold vs 6", 7'h4F);
    apply(4'd9, 1'b1, 1'b0, 1'b1, e); check("R3 blank while held", 7'h00);
    apply(4'd1, 1'b1, 1'b1, 1'b0, e); check("R2 test while held", 7'h7F);
    apply(4'd2, 1'b1, 1'b1, 1'b1, e); check("R7 held survives overrides", 7'h4F);
    apply(4'd7, 1'b0, 1'b0, 1'b1, e); check("R3 blank while loading", 7'h00);
    apply(4'd0, 1'b1, 1'b1, 1'b1, e); check("R7 load under blanking", 7'h07);
  endtask

  task automatic t_sweep();
    logic [6:0] e;
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 8; k++) begin
        apply(4'(c), k[0], k[1], k[2], e);
        check("R4 R7 control sweep", e);
      end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R8 reset state", 7'h00);
    rst_ni = 1'b1;
    t_reset();
    t_decode_all();
    t_overrides();
    t_hold();
    t_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule